// File: doc/BRIEF.md
# Four-Channel Compare and PWM Timer

This block is a 16-bit timer that drives four compare channels. Each channel has an enable, a compare value, an output pin and a match flag. Software programs it through a simple write bus with a strobe, an address and data. A reload value sets the length of the period. The timer runs in one of three modes. Basic compare mode counts up or down and toggles a pin on each match. Asymmetrical PWM always counts down. Symmetrical PWM counts up to the reload value and back down to zero, which gives centre-aligned pulses.

Compare values are double-buffered. A new value takes effect at the next reload, or at once while the timer is stopped, so a period is never cut short. A channel pin changes only on its own compare event, or on the period restart in asymmetrical PWM. Each pin can be inverted. The overflow flag and the four match flags are cleared by writing 1 to them. A mask selects which flags raise the single interrupt line.

Top module: `cmp_pwm_timer`

## Requirements
- R1: The reload event sets `ovf_flag` one cycle later. `irq` is high while any flag is set whose mask bit is 1. The mask sits at address 3, with bit 0 for overflow and bits 1..4 for channels A..D. With the mask at zero, `irq` stays low.
- R2: Channel enables sit at address 2, bits 3..0, for channels D..A. A disabled channel drives its `cmp_out` bit low, never sets its match flag and keeps its level.
- R3: Each running cycle in which an enabled channel's active compare value equals the count sets that channel's bit of `cmp_flag` on the next cycle.
- R4: Mode 01 is asymmetrical PWM. The mode field is bits 2..1 of the control register at address 0, where bit 0 is run and bit 3 is the down direction. In mode 01 the count steps reload, reload-1, ..., 0, reload, whatever bit 3 says. Each cycle at zero is a reload event.
- R5: Mode 10 is symmetrical PWM. From reset the count steps 0, 1, ..., reload, reload-1, ..., 0, 1, and so on. A reload event happens only at zero while counting down.
- R6: Mode 00 (and 11) is basic compare mode. With bit 3 clear, the count runs 0..reload and then wraps to 0; the cycle at or above reload is the reload event. With bit 3 set, the count runs down and loads the reload value at 0. In this mode a match toggles the channel level.
- R7: A channel level holds its value except on a compare event, or on a reload event in asymmetrical PWM.
- R8: In asymmetrical PWM a reload event sets the channel level to 1 and a match clears it to 0. When both happen in the same cycle, the match wins.
- R9: In symmetrical PWM a match toggles the level whether the count is going up or down.
- R10: Invert bits sit at address 2, bits 7..4, for channels D..A. An enabled channel drives `cmp_out` = level XOR invert. Level resets to 0.
- R11: A write to addresses 8..11 (channels A..D) loads a shadow register. The active compare value takes the shadow value at a reload event, or on every cycle while run is 0.
- R12: A write to address 4 clears each flag whose data bit is 1 (bit 0 is overflow, bits 1..4 are channels A..D). A flag that is set in the same cycle stays set.
- R13: With run at 0, the count holds its value. The reload value sits at address 1.
- R14: After reset, the count, the outputs, the flags and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current timer value |
| cmp_out | output | 4 | Compare outputs, bit 0 = channel A |
| ovf_flag | output | 1 | Reload (overflow) flag |
| cmp_flag | output | 4 | Match flags, bit 0 = channel A |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check the following on every cycle:
- the count steps downward in asymmetrical PWM, and by exactly one step in symmetrical PWM;
- the count holds while stopped;
- a channel level stays put without a compare or reload event, and drops after a match in asymmetrical PWM;
- the active compare value changes only at a reload or while stopped;
- matches and reloads set their flags, and a write-1 clears them.

The bench scenarios show what no single-cycle property can:
- the exact count sequence and reload points in each mode and direction;
- pulse position and width, including centre-aligned pulses;
- inverted polarity;
- a compare value written in mid-period taking effect only after the next reload;
- the interrupt mask.

// File: rtl/cpt_pkg.sv
// Shared definitions for the compare/PWM timer: mode encoding and the
// register address map. Assumes a 4-bit register address bus.
package cpt_pkg;

    typedef enum logic [1:0] {
        MODE_BASIC = 2'b00,
        MODE_ASYM  = 2'b01,
        MODE_SYM   = 2'b10
    } tmr_mode_e;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_RELOAD = 1;
    localparam int ADDR_CHAN   = 2;
    localparam int ADDR_IRQEN  = 3;
    localparam int ADDR_FLAG   = 4;
    localparam int ADDR_CMP0   = 8;

endpackage

// File: rtl/cpt_regs.sv
// Register file and flag block: control, reload, channel enable and
// invert, and interrupt mask. It also holds the sticky overflow and
// match flags (cleared by writing 1), and makes the write strobes for
// the compare shadow registers. Assumes 2*NCH <= W and NCH+1 <= W.
module cpt_regs
    import cpt_pkg::*;
#(
    parameter int W   = 16,
    parameter int AW  = 4,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic           reload_evt,
    input  logic [NCH-1:0] match_hit,
    output logic           run,
    output tmr_mode_e      mode,
    output logic           dir_dn,
    output logic [W-1:0]   reload_val,
    output logic [NCH-1:0] ch_en,
    output logic [NCH-1:0] ch_inv,
    output logic [NCH-1:0] cmp_wr,
    output logic           ovf_flag,
    output logic [NCH-1:0] cmp_flag,
    output logic           irq
);
    localparam int FW = NCH + 1;

    logic [FW-1:0] irq_en;
    logic wr_ctrl, wr_reload, wr_chan, wr_irqen, wr_flag;

    // Decode a write strobe for each register.
    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == AW'(ADDR_CTRL));
        wr_reload = wr_en && (wr_addr == AW'(ADDR_RELOAD));
        wr_chan   = wr_en && (wr_addr == AW'(ADDR_CHAN));
        wr_irqen  = wr_en && (wr_addr == AW'(ADDR_IRQEN));
        wr_flag   = wr_en && (wr_addr == AW'(ADDR_FLAG));
        for (int i = 0; i < NCH; i++) begin
            cmp_wr[i] = wr_en && (wr_addr == AW'(ADDR_CMP0 + i));
        end
    end

    // Control register: run, mode (11 folds onto basic), direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            mode   <= MODE_BASIC;
            dir_dn <= 1'b0;
        end else if (wr_ctrl) begin
            run    <= wr_data[0];
            mode   <= (wr_data[2:1] == 2'b11) ? MODE_BASIC : tmr_mode_e'(wr_data[2:1]);
            dir_dn <= wr_data[3];
        end
    end

    // Reload value, channel enable/invert, and interrupt mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= '0;
            ch_en      <= '0;
            ch_inv     <= '0;
            irq_en     <= '0;
        end else begin
            if (wr_reload) reload_val <= wr_data;
            if (wr_chan) begin
                ch_en  <= wr_data[NCH-1:0];
                ch_inv <= wr_data[2*NCH-1:NCH];
            end
            if (wr_irqen) irq_en <= wr_data[FW-1:0];
        end
    end

    // Overflow flag: set by a reload event, cleared by writing 1 to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_flag <= 1'b0;
        else if (reload_evt)            ovf_flag <= 1'b1;
        else if (wr_flag && wr_data[0]) ovf_flag <= 1'b0;
    end

    // Match flags: set by a channel match, cleared by writing 1 to bit i+1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_flag <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (match_hit[i])                   cmp_flag[i] <= 1'b1;
                else if (wr_flag && wr_data[i + 1]) cmp_flag[i] <= 1'b0;
            end
        end
    end

    // Interrupt request: any flag whose mask bit is set.
    assign irq = |({cmp_flag, ovf_flag} & irq_en);

    // R1
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_evt |=> ovf_flag);

    // R12
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && wr_data[0] && !reload_evt) |=> !ovf_flag);

    for (genvar g = 0; g < NCH; g++) begin : g_flag_chk
        // R3
        cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            match_hit[g] |=> cmp_flag[g]);
        // R2
        cmp_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[g] && !cmp_flag[g] && !(wr_chan && wr_data[g])) |=> !cmp_flag[g]);
    end

endmodule

// File: rtl/cpt_counter.sv
// Timer counter: steps the count according to the mode and flags the
// reload event (the start of a new period) combinationally from the
// current count. Symmetrical mode keeps its own direction state, which
// starts upward after reset. Holds its value when run is low.
module cpt_counter
    import cpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  tmr_mode_e    mode,
    input  logic         dir_dn,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         reload_evt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic going_dn;
    logic at_zero;
    logic at_top;

    // End-of-range detection shared by all modes.
    always_comb begin
        at_zero = (cnt == '0);
        at_top  = (cnt >= reload_val);
    end

    // Reload event: the cycle whose count ends the current period.
    always_comb begin
        unique case (mode)
            MODE_ASYM: reload_evt = at_zero;
            MODE_SYM:  reload_evt = going_dn && at_zero;
            default:   reload_evt = dir_dn ? at_zero : at_top;
        endcase
        reload_evt = reload_evt && run;
    end

    // Count update and direction tracking per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            going_dn <= 1'b0;
        end else if (run) begin
            unique case (mode)
                MODE_ASYM: begin
                    going_dn <= 1'b1;
                    cnt      <= at_zero ? reload_val : cnt - ONE;
                end
                MODE_SYM: begin
                    if (!going_dn) begin
                        if (at_top) begin
                            going_dn <= 1'b1;
                            cnt      <= at_zero ? '0 : cnt - ONE;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end else if (at_zero) begin
                        going_dn <= 1'b0;
                        cnt      <= (reload_val == '0) ? '0 : ONE;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: begin
                    going_dn <= dir_dn;
                    if (dir_dn) cnt <= at_zero ? reload_val : cnt - ONE;
                    else        cnt <= at_top ? '0 : cnt + ONE;
                end
            endcase
        end
    end

    // R4
    asym_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_ASYM && !at_zero) |=> (cnt == $past(cnt) - ONE));

    // R5
    sym_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_SYM && reload_val != '0 && cnt <= reload_val)
        |=> (cnt == $past(cnt) + ONE || cnt == $past(cnt) - ONE));

    // R13
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

endmodule

// File: rtl/cpt_channel.sv
// One compare channel: a shadow and an active compare register, match
// detection and the output level. The level is set or toggled by the
// mode's rule, and the polarity mux comes after it. The shadow passes
// to the active register at a reload event or while the timer is stopped.
module cpt_channel
    import cpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  tmr_mode_e    mode,
    input  logic         enable,
    input  logic         invert,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    input  logic         reload_evt,
    output logic         match_hit,
    output logic         pin
);
    logic [W-1:0] shadow;
    logic [W-1:0] active;
    logic         level;

    // Shadow compare register written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow <= '0;
        else if (wr_stb) shadow <= wr_data;
    end

    // Active compare register: loads at reload, or tracks while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                   active <= '0;
        else if (!run || reload_evt)  active <= shadow;
    end

    // A match counts only while running on an enabled channel.
    assign match_hit = run && enable && (cnt == active);

    // Level update: asym sets at reload, clears on match; others toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
        end else if (match_hit) begin
            level <= (mode == MODE_ASYM) ? 1'b0 : ~level;
        end else if (enable && mode == MODE_ASYM && reload_evt) begin
            level <= 1'b1;
        end
    end

    // Output polarity; a disabled channel drives low.
    assign pin = enable && (level ^ invert);

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_hit && !(mode == MODE_ASYM && reload_evt)) |=> $stable(level));

    // R8
    asym_match_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && mode == MODE_ASYM) |=> !level);

    // R11
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !reload_evt) |=> $stable(active));

endmodule

// File: rtl/cmp_pwm_timer.sv
// Top of the four-channel compare/PWM timer. Joins the register block,
// the counter and one compare channel per output. Assumes the write
// data width equals the timer width.
module cmp_pwm_timer
    import cpt_pkg::*;
#(
    parameter int W   = 16,
    parameter int AW  = 4,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    output logic [W-1:0]   count,
    output logic [NCH-1:0] cmp_out,
    output logic           ovf_flag,
    output logic [NCH-1:0] cmp_flag,
    output logic           irq
);
    logic           run;
    tmr_mode_e      mode;
    logic           dir_dn;
    logic [W-1:0]   reload_val;
    logic [NCH-1:0] ch_en;
    logic [NCH-1:0] ch_inv;
    logic [NCH-1:0] cmp_wr;
    logic [NCH-1:0] match_hit;
    logic           reload_evt;

    cpt_regs #(.W(W), .AW(AW), .NCH(NCH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .reload_evt (reload_evt),
        .match_hit  (match_hit),
        .run        (run),
        .mode       (mode),
        .dir_dn     (dir_dn),
        .reload_val (reload_val),
        .ch_en      (ch_en),
        .ch_inv     (ch_inv),
        .cmp_wr     (cmp_wr),
        .ovf_flag   (ovf_flag),
        .cmp_flag   (cmp_flag),
        .irq        (irq)
    );

    cpt_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .mode       (mode),
        .dir_dn     (dir_dn),
        .reload_val (reload_val),
        .cnt        (count),
        .reload_evt (reload_evt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        cpt_channel #(.W(W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (run),
            .mode       (mode),
            .enable     (ch_en[c]),
            .invert     (ch_inv[c]),
            .wr_stb     (cmp_wr[c]),
            .wr_data    (wr_data),
            .cnt        (count),
            .reload_evt (reload_evt),
            .match_hit  (match_hit[c]),
            .pin        (cmp_out[c])
        );
    end

endmodule

// File: tb/test_cmp_pwm_timer.sv
// Scoreboard bench: scenario tasks push expected values tagged with a
// future cycle, and a monitor on the falling edge pops and compares them.
module test_cmp_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic [3:0]  cmp_out;
    logic        ovf_flag;
    logic [3:0]  cmp_flag;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    kind;   // 0 count, 1 cmp_out, 2 {cmp_flag,ovf_flag}, 3 irq
        int    val;
        string tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    cmp_pwm_timer i_cmp_pwm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .cmp_out(cmp_out),
        .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq(irq)
    );

    // Monitor: compare every item due this cycle.
    always @(negedge clk) begin
        cyc = cyc + 1;
        for (int k = sb.size() - 1; k >= 0; k--) begin
            if (sb[k].at <= cyc) begin
                int act;
                case (sb[k].kind)
                    0:       act = int'(count);
                    1:       act = int'(cmp_out);
                    2:       act = int'({cmp_flag, ovf_flag});
                    default: act = int'(irq);
                endcase
                checks++;
                if (sb[k].at != cyc || act != sb[k].val) begin
                    errors++;
                    $display("FAIL %s kind=%0d cycle=%0d actual=%0h expected=%0h",
                             sb[k].tag, sb[k].kind, cyc, act, sb[k].val);
                end
                sb.delete(k);
            end
        end
    end

    // Push an expected value for the state j clock edges from now.
    task automatic expect_at(input int j, input int kind, input int val, input string tag);
        item_t it;
        it.at = cyc + 1 + j;
        it.kind = kind;
        it.val = val;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 16'(data);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(posedge clk);
        #1;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..all) actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R14 reset state
        do_reset();
        expect_at(0, 0, 0, "R14");
        expect_at(0, 1, 0, "R14");
        expect_at(0, 2, 0, "R14");
        expect_at(0, 3, 0, "R14");
        drain();

        // Asymmetrical PWM, direction bit up (ignored), A plain, B inverted, C disabled
        wr(1, 5);          // reload
        wr(8, 2);          // A
        wr(9, 2);          // B
        wr(10, 3);         // C (disabled)
        wr(2, 16'h23);     // enable A,B; invert B
        wr(3, 1);          // irq on overflow
        wr(0, 16'h3);      // run, mode asym, dir up
        expect_at(0, 0, 0, "R4");
        expect_at(1, 0, 5, "R4");
        expect_at(2, 0, 4, "R4");
        expect_at(4, 0, 2, "R4");
        expect_at(6, 0, 0, "R4");
        expect_at(7, 0, 5, "R4");
        expect_at(9, 0, 3, "R4");
        expect_at(0, 1, 4'h2, "R10");
        expect_at(1, 1, 4'h1, "R8");
        expect_at(4, 1, 4'h1, "R7");
        expect_at(5, 1, 4'h2, "R11");
        expect_at(6, 1, 4'h2, "R7");
        expect_at(7, 1, 4'h1, "R8");
        expect_at(9, 1, 4'h0, "R11");
        expect_at(0, 2, 5'h00, "R1");
        expect_at(1, 2, 5'h01, "R1");
        expect_at(5, 2, 5'h07, "R3");
        expect_at(6, 2, 5'h07, "R2");
        expect_at(0, 3, 0, "R1");
        expect_at(1, 3, 1, "R1");
        wait_edges(2);
        wr(8, 4);          // new A value mid-period, used after next reload
        wait_edges(6);
        wr(4, 1);          // clear overflow flag
        expect_at(0, 2, 5'h06, "R12");
        expect_at(0, 3, 0, "R12");
        wr(0, 16'h2);      // stop
        expect_at(0, 0, 1, "R13");
        expect_at(3, 0, 1, "R13");
        drain();

        // Symmetrical PWM
        do_reset();
        wr(1, 4);
        wr(8, 2);
        wr(2, 16'h01);
        wr(3, 16'h02);     // irq on channel A
        wr(0, 16'h5);      // run, mode sym
        begin
            int seq [11] = '{0, 1, 2, 3, 4, 3, 2, 1, 0, 1, 2};
            for (int j = 0; j < 11; j++) expect_at(j, 0, seq[j], "R5");
        end
        expect_at(2, 1, 0, "R9");
        expect_at(3, 1, 1, "R9");
        expect_at(6, 1, 1, "R9");
        expect_at(7, 1, 0, "R9");
        expect_at(11, 1, 1, "R9");
        expect_at(2, 2, 5'h00, "R3");
        expect_at(3, 2, 5'h02, "R3");
        expect_at(8, 2, 5'h02, "R5");
        expect_at(9, 2, 5'h03, "R5");
        expect_at(2, 3, 0, "R1");
        expect_at(3, 3, 1, "R3");
        drain();

        // Basic compare, counting up
        do_reset();
        wr(1, 3);
        wr(9, 1);
        wr(2, 16'h02);
        wr(0, 16'h1);
        begin
            int seq [6] = '{0, 1, 2, 3, 0, 1};
            for (int j = 0; j < 6; j++) expect_at(j, 0, seq[j], "R6");
        end
        expect_at(1, 1, 0, "R6");
        expect_at(2, 1, 2, "R6");
        expect_at(5, 1, 2, "R7");
        expect_at(6, 1, 0, "R6");
        expect_at(2, 2, 5'h04, "R3");
        expect_at(4, 2, 5'h05, "R1");
        expect_at(4, 3, 0, "R1");
        drain();

        // Basic compare, counting down
        do_reset();
        wr(1, 3);
        wr(9, 2);
        wr(2, 16'h02);
        wr(0, 16'h9);
        begin
            int seq [6] = '{0, 3, 2, 1, 0, 3};
            for (int j = 0; j < 6; j++) expect_at(j, 0, seq[j], "R6");
        end
        expect_at(2, 1, 0, "R6");
        expect_at(3, 1, 2, "R6");
        expect_at(6, 1, 2, "R7");
        expect_at(7, 1, 0, "R6");
        expect_at(1, 2, 5'h01, "R1");
        drain();

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule